// File: doc/BRIEF.md
# Randomized Sample Interval Counter

This block picks individual members of an event stream for sampling. A 32-bit primary down-counter counts events while profiling is enabled; when it runs out it is reloaded from a programmable interval. If randomization is both built in and requested, the run-out does not pick the event at once. Instead an 8-bit secondary down-counter is loaded from an internal pseudorandom source, and the sample is taken when that counter runs out. This spreads the sample points so they do not lock onto periodic behaviour in the event stream. The primary counter keeps counting while the secondary runs.

Software sees both counters through one 64-bit read/write context word. It writes zero before a profiling session and saves or restores the word on a context switch. Each selected event produces a one-cycle pulse on the sample-select output.

Top module: `sample_interval_counter`

## Requirements
- R1: The context word reads as {secondary[7:0] at bits 63:56, zeros at bits 55:32, primary[31:0] at bits 31:0}. A write loads the primary count from bits 31:0 and, when randomization is built in, loads the secondary count from bits 63:56. Bits 55:32 always read zero.
- R2: With RANDOM_EN=0, bits 63:56 always read 8'hFF, writes to them are ignored, and rand_req has no effect.
- R3: While profiling is enabled, each event with a nonzero primary count that is not 1 decrements the primary count by one.
- R4: In a cycle where prof_en is high, it was low in the previous cycle, and the primary count is zero, the primary count is loaded from reload_val. An event in that cycle is not counted.
- R5: An event that finds the primary count at 1 while randomization is off (rand_req low or RANDOM_EN=0) is selected, and the primary count is reloaded from reload_val.
- R6: An event that finds the primary count at 1 while randomization is on reloads the primary count and loads the secondary count with bits [7:0] of the current LFSR state. It is not selected unless R9 applies.
- R7: While the secondary count is nonzero, each counted event also decrements it by one. The event that finds it at 1 is selected. A secondary load in the same cycle (R6) overrides the decrement.
- R8: While prof_en is low and no write occurs, neither count changes and no event is selected.
- R9: If the value loaded into the secondary count by R6 is zero, the event that caused the load is selected.
- R10: A context write in a cycle takes priority: any event in that cycle is neither counted nor selected.
- R11: sample_o is registered. It is high in the single cycle after the clock edge that captured a selected event, and low otherwise.
- R12: The LFSR is 16 bits and is set to 16'hACE1 by reset. It advances on every clock to {s[14:0], s[15]^s[14]^s[12]^s[3]}.
- R13: Synchronous reset clears both counts and sample_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prof_en | input | 1 | Profiling enable level |
| evt | input | 1 | One member of the event population this cycle |
| reload_val | input | 32 | Primary reload interval |
| rand_req | input | 1 | Request interval randomization |
| ctx_wr_en | input | 1 | Write the context word this cycle |
| ctx_wr_data | input | 64 | Context word to write |
| ctx_rd_data | output | 64 | Current context word |
| sample_o | output | 1 | One-cycle sample-select pulse |

## Verification
A context write, an enable edge or an event takes effect at the next rising edge, so ctx_rd_data shows the new counts one cycle after the stimulus is applied. sample_o for a selected event is also due in that cycle. The bench drives inputs just after a falling edge and updates a behavioural model at the rising edge. It compares both outputs of a randomizing instance and a non-randomizing instance at the following falling edge, so every expected value lines up with the cycle in which the design's registers change.

// File: rtl/sic_pkg.sv
package sic_pkg;

    localparam int PRI_W   = 32;
    localparam int SEC_W   = 8;
    localparam int CTX_W   = 64;
    localparam int RSVD_W  = CTX_W - PRI_W - SEC_W;
    localparam int LFSR_W  = 16;

    typedef logic [PRI_W-1:0]  pri_t;
    typedef logic [SEC_W-1:0]  sec_t;
    typedef logic [LFSR_W-1:0] lfsr_t;

    // Layout of the saved context word: secondary on top, primary at bottom.
    typedef struct packed {
        sec_t              sec;
        logic [RSVD_W-1:0] rsvd;
        pri_t              pri;
    } ctx_t;

    // Maximal-length feedback x^16 + x^15 + x^13 + x^4 + 1, shifting left.
    function automatic lfsr_t lfsr_advance(input lfsr_t s);
        return {s[LFSR_W-2:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
    endfunction

    function automatic ctx_t ctx_pack(input sec_t s, input pri_t p);
        ctx_t c;
        c.sec  = s;
        c.rsvd = '0;
        c.pri  = p;
        return c;
    endfunction

endpackage

// File: rtl/sic_lfsr.sv
module sic_lfsr
    import sic_pkg::*;
#(
    parameter lfsr_t SEED = 16'hACE1
) (
    input  logic  clk,
    input  logic  rst,
    output lfsr_t state
);
    lfsr_t state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEED;
        else     state_q <= lfsr_advance(state_q);
    end

    assign state = state_q;
endmodule

// File: rtl/sic_primary.sv
module sic_primary
    import sic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  pri_t wr_val,
    input  logic entry_load,
    input  logic step,
    input  pri_t reload,
    output pri_t count,
    output logic expire
);
    pri_t cnt_q;
    logic at_one;
    logic nonzero;

    assign at_one  = (cnt_q == pri_t'(1));
    assign nonzero = (cnt_q != '0);
    assign expire  = step && at_one;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_en) begin
            cnt_q <= wr_val;
        end else if (entry_load) begin
            cnt_q <= reload;
        end else if (step && nonzero) begin
            cnt_q <= at_one ? reload : cnt_q - pri_t'(1);
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/sic_secondary.sv
module sic_secondary
    import sic_pkg::*;
#(
    parameter bit PRESENT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  sec_t wr_val,
    input  logic step,
    input  logic load_rand,
    input  sec_t rand_val,
    output sec_t count,
    output logic hit
);
    generate
        if (PRESENT) begin : g_counter
            sec_t cnt_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                end else if (wr_en) begin
                    cnt_q <= wr_val;
                end else if (step) begin
                    if (load_rand)          cnt_q <= rand_val;
                    else if (cnt_q != '0)   cnt_q <= cnt_q - sec_t'(1);
                end
            end

            assign count = cnt_q;
            assign hit   = step && (cnt_q == sec_t'(1));
        end else begin : g_absent
            logic unused_ok;
            assign unused_ok = &{1'b0, clk, rst, wr_en, wr_val, step, load_rand, rand_val};
            assign count = '1;
            assign hit   = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/sample_interval_counter.sv
module sample_interval_counter
    import sic_pkg::*;
#(
    parameter bit    RANDOM_EN = 1'b1,
    parameter lfsr_t LFSR_SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prof_en,
    input  logic             evt,
    input  logic [PRI_W-1:0] reload_val,
    input  logic             rand_req,
    input  logic             ctx_wr_en,
    input  logic [CTX_W-1:0] ctx_wr_data,
    output logic [CTX_W-1:0] ctx_rd_data,
    output logic             sample_o
);
    ctx_t  wr_ctx;
    pri_t  pri_cnt;
    sec_t  sec_cnt;
    lfsr_t lfsr_state;
    sec_t  rand_byte;
    logic  prev_en_q;
    logic  entry_load;
    logic  step;
    logic  rnd_on;
    logic  pri_expire;
    logic  sec_hit;
    logic  load_rand;
    logic  sample_d;
    logic  sample_q;

    assign wr_ctx    = ctx_t'(ctx_wr_data);
    assign rand_byte = lfsr_state[SEC_W-1:0];
    assign rnd_on    = RANDOM_EN && rand_req;

    // Enable edge with an empty primary count arms a fresh interval.
    assign entry_load = !ctx_wr_en && prof_en && !prev_en_q && (pri_cnt == '0);
    assign step       = !ctx_wr_en && prof_en && evt && !entry_load;
    assign load_rand  = pri_expire && rnd_on;
    assign sample_d   = sec_hit || (pri_expire && (!rnd_on || rand_byte == '0));

    sic_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .state (lfsr_state)
    );

    sic_primary u_primary (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (ctx_wr_en),
        .wr_val     (wr_ctx.pri),
        .entry_load (entry_load),
        .step       (step),
        .reload     (reload_val),
        .count      (pri_cnt),
        .expire     (pri_expire)
    );

    sic_secondary #(.PRESENT(RANDOM_EN)) u_secondary (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (ctx_wr_en),
        .wr_val    (wr_ctx.sec),
        .step      (step),
        .load_rand (load_rand),
        .rand_val  (rand_byte),
        .count     (sec_cnt),
        .hit       (sec_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_en_q <= 1'b0;
            sample_q  <= 1'b0;
        end else begin
            prev_en_q <= prof_en;
            sample_q  <= sample_d;
        end
    end

    assign ctx_rd_data = ctx_pack(sec_cnt, pri_cnt);
    assign sample_o    = sample_q;
endmodule

// File: rtl/sic_checker.sv
module sic_checker
    import sic_pkg::*;
#(
    parameter bit RANDOM_EN = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             prof_en,
    input logic             evt,
    input logic             ctx_wr_en,
    input logic [CTX_W-1:0] ctx_wr_data,
    input logic [CTX_W-1:0] ctx_rd_data,
    input logic             sample_o
);
    logic [PRI_W-1:0] pri_v;
    assign pri_v = ctx_rd_data[PRI_W-1:0];

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        ctx_rd_data[CTX_W-SEC_W-1:PRI_W] == '0);

    a_r1_write_load: assert property (@(posedge clk) disable iff (rst)
        ctx_wr_en |=> pri_v == $past(ctx_wr_data[PRI_W-1:0]));

    a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
        (prof_en && $past(prof_en) && !$past(rst) && evt && !ctx_wr_en && pri_v > 32'd1)
        |=> pri_v == $past(pri_v) - 32'd1);

    a_r8_hold_disabled: assert property (@(posedge clk) disable iff (rst)
        (!prof_en && !ctx_wr_en) |=> ($stable(ctx_rd_data) && !sample_o));

    a_r10_write_no_sample: assert property (@(posedge clk) disable iff (rst)
        ctx_wr_en |=> !sample_o);

    a_r11_sample_cause: assert property (@(posedge clk) disable iff (rst)
        sample_o |-> $past(prof_en && evt && !ctx_wr_en));

    generate
        if (!RANDOM_EN) begin : g_fixed
            a_r2_all_ones: assert property (@(posedge clk) disable iff (rst)
                ctx_rd_data[CTX_W-1:CTX_W-SEC_W] == '1);
        end
    endgenerate
endmodule

bind sample_interval_counter sic_checker #(.RANDOM_EN(RANDOM_EN)) u_sic_checker (
    .clk         (clk),
    .rst         (rst),
    .prof_en     (prof_en),
    .evt         (evt),
    .ctx_wr_en   (ctx_wr_en),
    .ctx_wr_data (ctx_wr_data),
    .ctx_rd_data (ctx_rd_data),
    .sample_o    (sample_o)
);

// File: tb/sample_interval_counter_tb_top.sv
module sample_interval_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prof_en = 1'b0;
    logic        evt = 1'b0;
    logic [31:0] reload_val = 32'd0;
    logic        rand_req = 1'b0;
    logic        ctx_wr_en = 1'b0;
    logic [63:0] ctx_wr_data = 64'd0;
    logic [63:0] rd_r, rd_f;
    logic        smp_r, smp_f;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string tag = "R13";

    // Behavioural reference: index 0 randomizing, index 1 fixed.
    logic [31:0] m_pri [2];
    logic [7:0]  m_sec [2];
    bit          m_prev[2];
    bit          m_samp[2];
    logic [15:0] m_lfsr;
    int          sample_total = 0;

    always #10 clk = ~clk;

    sample_interval_counter #(.RANDOM_EN(1'b1)) dut_i (
        .clk(clk), .rst(rst), .prof_en(prof_en), .evt(evt),
        .reload_val(reload_val), .rand_req(rand_req),
        .ctx_wr_en(ctx_wr_en), .ctx_wr_data(ctx_wr_data),
        .ctx_rd_data(rd_r), .sample_o(smp_r));

    sample_interval_counter #(.RANDOM_EN(1'b0)) dut_fixed_i (
        .clk(clk), .rst(rst), .prof_en(prof_en), .evt(evt),
        .reload_val(reload_val), .rand_req(rand_req),
        .ctx_wr_en(ctx_wr_en), .ctx_wr_data(ctx_wr_data),
        .ctx_rd_data(rd_f), .sample_o(smp_f));

    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            bit rs, wr, el, st, exp_hit, sec_hit, ro;
            logic [7:0] rb;
            rs = (k == 0);
            rb = m_lfsr[7:0];
            if (rst) begin
                m_pri[k] = 0; m_sec[k] = 0; m_prev[k] = 0; m_samp[k] = 0;
            end else begin
                wr = ctx_wr_en;
                el = !wr && prof_en && !m_prev[k] && m_pri[k] == 0;
                st = !wr && prof_en && evt && !el;
                m_samp[k] = 0;
                if (wr) begin
                    m_pri[k] = ctx_wr_data[31:0];
                    if (rs) m_sec[k] = ctx_wr_data[63:56];
                end else if (el) begin
                    m_pri[k] = reload_val;
                end else if (st) begin
                    ro      = rs && rand_req;
                    exp_hit = (m_pri[k] == 1);
                    sec_hit = rs && (m_sec[k] == 1);
                    if (m_pri[k] != 0) m_pri[k] = exp_hit ? reload_val : m_pri[k] - 1;
                    if (rs) begin
                        if (exp_hit && ro)     m_sec[k] = rb;
                        else if (m_sec[k] != 0) m_sec[k] = m_sec[k] - 1;
                    end
                    m_samp[k] = sec_hit || (exp_hit && (!ro || rb == 0));
                end
                m_prev[k] = prof_en;
            end
        end
        if (rst) m_lfsr = 16'hACE1;
        else     m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[14] ^ m_lfsr[12] ^ m_lfsr[3]};
    end

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic compare();
        check64(tag, rd_r, {m_sec[0], 24'd0, m_pri[0]});
        check64({tag, "/R2"}, rd_f, {8'hFF, 24'd0, m_pri[1]});
        check1({tag, "/R11"}, smp_r, m_samp[0]);
        check1({tag, "/R11"}, smp_f, m_samp[1]);
        if (smp_r) sample_total++;
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
            compare();
        end
    endtask

    task automatic ctx_write(input logic [63:0] v);
        ctx_wr_en = 1'b1; ctx_wr_data = v;
        tick(1);
        ctx_wr_en = 1'b0;
    endtask

    initial begin
        // R13: reset state
        tick(3);
        rst = 1'b0;
        tick(1);
        check64("R13", rd_r, 64'd0);
        check1("R13", smp_r, 1'b0);

        // R1 / R2: layout and reserved bits
        tag = "R1";
        ctx_write(64'hFFFF_FFFF_FFFF_FFFF);
        check64("R1", rd_r, {8'hFF, 24'd0, 32'hFFFF_FFFF});
        check64("R2", rd_f, {8'hFF, 24'd0, 32'hFFFF_FFFF});
        ctx_write(64'h5A00_1234_0000_0007);
        check64("R1", rd_r, 64'h5A00_0000_0000_0007);
        ctx_write(64'd0);

        // R8: disabled, events do nothing
        tag = "R8";
        reload_val = 32'd5;
        evt = 1'b1;
        tick(6);
        check64("R8", rd_r, 64'd0);

        // R4 then R3 / R5: periodic selection without randomization
        tag = "R4";
        evt = 1'b1; prof_en = 1'b1;
        tick(1);
        check64("R4", rd_r, 64'd5);
        tag = "R3";
        tick(3);
        check64("R3", rd_r, 64'd2);
        tag = "R5";
        tick(2);
        check1("R5", smp_r, 1'b1);
        check64("R5", rd_r, 64'd5);
        tick(20);

        // R10: write wins over an event
        tag = "R10";
        ctx_write(64'd1);
        check1("R10", smp_r, 1'b0);
        check64("R10", rd_r, 64'd1);
        evt = 1'b0;
        tick(3);
        check64("R10", rd_r, 64'd1);

        // R6 / R7: randomized intervals with sparse events
        tag = "R6";
        rand_req = 1'b1; reload_val = 32'd3;
        evt = 1'b1;
        tick(1);
        check1("R6", smp_r, m_samp[0]);
        tag = "R7";
        for (int i = 0; i < 4000; i++) begin
            evt = ($urandom_range(0, 3) != 0);
            tick(1);
        end

        // R9 / R12: every event expires, zero LFSR bytes select at once
        tag = "R9";
        reload_val = 32'd1;
        ctx_write(64'd1);
        evt = 1'b1;
        sample_total = 0;
        tick(3000);
        check1("R9", (sample_total > 0) ? 1'b1 : 1'b0, 1'b1);

        // R12 / R8 / R10: random mix of enables, writes and intervals
        tag = "R12";
        for (int i = 0; i < 12000; i++) begin
            prof_en    = ($urandom_range(0, 19) != 0);
            evt        = $urandom_range(0, 1) != 0;
            rand_req   = ($urandom_range(0, 7) != 0);
            reload_val = $urandom_range(0, 40);
            ctx_wr_en  = ($urandom_range(0, 199) == 0);
            ctx_wr_data = {$urandom_range(0, 255) & 32'hFF, 24'hABCDEF, 32'(30'($urandom_range(0, 50)))};
            tick(1);
        end
        ctx_wr_en = 1'b0;

        // R2: fixed instance ignores rand_req
        tag = "R2";
        rand_req = 1'b1; reload_val = 32'd2;
        ctx_write(64'd2);
        prof_en = 1'b1; evt = 1'b1;
        tick(2);
        check1("R2", smp_f, 1'b1);
        check64("R2", rd_f, {8'hFF, 24'd0, 32'd2});

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule